// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block is the programmable divider in the feedback path of a fractional-N frequency synthesizer. The divided clock arrives as a single-cycle enable (`in_tick`) on the system clock. Each output period lasts a whole number of ticks. That number is the integer setting plus a small signed offset, and the offset is drawn once per period from a three-stage cascaded-accumulator noise shaper. Over many periods the mean division ratio is therefore INT + FRAC/MOD, while the quantisation error is pushed to high frequencies. The modulus is any value from 2 to 4095 and need not be a power of two, because every accumulator wraps at MOD.

New settings are offered with a `load` strobe and held in a one-deep pending slot. They take effect when the period that is running ends, so no period is ever cut short. Settings outside the legal ranges are refused: `cfg_err` is raised and the block keeps running on what it already had. The control is a two-state machine. `ST_IDLE` is entered at reset and emits nothing. The transition `IDLE_TO_RUN` happens on the first clock that finds a legal pending setting. `ST_RUN` then holds for good, with the self-transition `RUN_HOLD`. In `ST_RUN`, every period boundary either takes the pending setting or steps the shaper.

Top module: `frac_n_divider`

## Requirements
- R1: After reset `div_pulse`, `cur_ratio` and `cfg_err` are 0. No pulse appears until a legal setting has been applied, and ticks that arrive before then are not counted.
- R2: A `load` is legal when 31 <= `int_in` <= 511, 2 <= `mod_in` <= 4095 and `frac_in` < `mod_in`. A legal load clears `cfg_err` on the next clock and becomes the pending setting. An illegal load sets `cfg_err` on the next clock and changes neither the pending nor the running setting.
- R3: A pending setting is applied on the clock after it is loaded if the block is idle. Otherwise it is applied at the tick that ends the current period, and that period keeps its full length.
- R4: A period of `cur_ratio` ticks ends on its last tick. `div_pulse` is high for exactly one clock, on the clock after that tick. On the same clock `cur_ratio` changes to the length of the period that has just begun.
- R5: The offset is c1 + (c2 - c2') + (c3 - 2*c3' + c3''), where ck is the stage-k wrap carry and primes mark earlier boundaries. It lies in -3..+4, so every period lasts between INT-3 and INT+4 ticks.
- R6: While FRAC is 0, every period lasts exactly INT ticks.
- R7: When a setting is applied, all three accumulators are seeded with FRAC and the carry history is cleared. The first period under it is exactly INT ticks, and the offset sequence that follows is the same every time that setting is applied.
- R8: Over the first MOD periods after a setting is applied, the total tick count lies between MOD*INT+FRAC-1 and MOD*INT+FRAC+2.
- R9: With `in_tick` low the period does not advance, and no pulse is produced.
- R10: A legal load that arrives on the same clock as a period-ending tick does not affect that boundary. The boundary applies the setting that was already pending, if there is one, and the new load waits for the following boundary.
- R11: When several legal loads arrive within one period, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_tick | input | 1 | One pulse per cycle of the clock being divided |
| load | input | 1 | Capture `int_in`, `frac_in`, `mod_in` as the next setting |
| int_in | input | 9 | Integer part of the ratio |
| frac_in | input | 12 | Fractional numerator |
| mod_in | input | 12 | Fractional denominator (modulus) |
| div_pulse | output | 1 | One-clock pulse at the end of each output period |
| cur_ratio | output | 10 | Length in ticks of the period now running |
| cfg_err | output | 1 | Last load was illegal |

## Verification
Two functions can fall in the same clock: a `load` strobe and the tick that closes a period. That boundary may in turn apply an older pending setting. The bench follows the divider's remaining-tick count in its behavioural model. It raises `load` on exactly the clock whose tick ends the period, while a different setting is already pending. It then expects the boundary pulse to report the older setting's INT, and the following boundary to report the new one. All of this is also compared clock by clock against the model, which checks pulses, ratio and error flag.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int INT_W   = 9;
    localparam int MOD_W   = 12;
    localparam int RAT_W   = INT_W + 1;
    localparam int OFS_W   = 4;
    localparam int STAGES  = 3;
    localparam int INT_MIN = 31;
    localparam int MOD_MIN = 2;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } dstate_t;

    typedef struct packed {
        logic [INT_W-1:0] int_v;
        logic [MOD_W-1:0] frac_v;
        logic [MOD_W-1:0] mod_v;
    } cfg_t;

endpackage

// File: rtl/frac_div_cfg.sv
module frac_div_cfg
    import frac_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [INT_W-1:0] int_in,
    input  logic [MOD_W-1:0] frac_in,
    input  logic [MOD_W-1:0] mod_in,
    input  logic             take,
    output logic             pend_valid,
    output cfg_t             pend,
    output logic             cfg_err
);

    logic legal;

    always_comb begin
        legal = (int_in >= INT_W'(INT_MIN)) &&
                (mod_in >= MOD_W'(MOD_MIN)) &&
                (frac_in < mod_in);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend       <= '0;
            cfg_err    <= 1'b0;
        end else begin
            if (take) begin
                pend_valid <= 1'b0;
            end
            if (load) begin
                if (legal) begin
                    pend.int_v  <= int_in;
                    pend.frac_v <= frac_in;
                    pend.mod_v  <= mod_in;
                    pend_valid  <= 1'b1;
                    cfg_err     <= 1'b0;
                end else begin
                    cfg_err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/frac_div_mash.sv
module frac_div_mash
    import frac_div_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [MOD_W-1:0]        frac,
    input  logic [MOD_W-1:0]        modv,
    input  logic                    seed,
    input  logic [MOD_W-1:0]        seed_val,
    input  logic                    step,
    output logic signed [OFS_W-1:0] offset
);

    logic [MOD_W-1:0] st_in [STAGES];
    logic [MOD_W-1:0] acc_n [STAGES];
    logic             carry [STAGES];
    logic             c2_d, c3_d, c3_dd;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic [MOD_W-1:0] acc_r;
        logic [MOD_W:0]   sum;

        if (k == 0) begin : g_first
            assign st_in[k] = frac;
        end else begin : g_chain
            assign st_in[k] = acc_n[k-1];
        end

        assign sum      = {1'b0, acc_r} + {1'b0, st_in[k]};
        assign carry[k] = (sum >= {1'b0, modv});
        assign acc_n[k] = carry[k] ? (sum[MOD_W-1:0] - modv) : sum[MOD_W-1:0];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_r <= '0;
            end else if (seed) begin
                acc_r <= seed_val;
            end else if (step) begin
                acc_r <= acc_n[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || seed) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else if (step) begin
            c2_d  <= carry[1];
            c3_d  <= carry[2];
            c3_dd <= c3_d;
        end
    end

    always_comb begin
        offset = OFS_W'(carry[0])
               + OFS_W'(carry[1]) - OFS_W'(c2_d)
               + OFS_W'(carry[2]) - OFS_W'({c3_d, 1'b0}) + OFS_W'(c3_dd);
    end

endmodule

// File: rtl/frac_n_divider.sv
module frac_n_divider
    import frac_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_tick,
    input  logic             load,
    input  logic [INT_W-1:0] int_in,
    input  logic [MOD_W-1:0] frac_in,
    input  logic [MOD_W-1:0] mod_in,
    output logic             div_pulse,
    output logic [RAT_W-1:0] cur_ratio,
    output logic             cfg_err
);

    dstate_t                 st_q, st_d;
    cfg_t                    act_q;
    cfg_t                    pend;
    logic                    pend_valid;
    logic [RAT_W-1:0]        cnt_q;
    logic signed [OFS_W-1:0] offset;
    logic                    boundary, apply, step;
    logic [RAT_W-1:0]        next_ratio, pend_ratio;

    frac_div_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .int_in     (int_in),
        .frac_in    (frac_in),
        .mod_in     (mod_in),
        .take       (apply),
        .pend_valid (pend_valid),
        .pend       (pend),
        .cfg_err    (cfg_err)
    );

    frac_div_mash u_mash (
        .clk      (clk),
        .rst_n    (rst_n),
        .frac     (act_q.frac_v),
        .modv     (act_q.mod_v),
        .seed     (apply),
        .seed_val (pend.frac_v),
        .step     (step),
        .offset   (offset)
    );

    always_comb begin
        boundary   = (st_q == ST_RUN) && in_tick && (cnt_q == '0);
        apply      = pend_valid && ((st_q == ST_IDLE) || boundary);
        step       = boundary && !pend_valid;
        next_ratio = {1'b0, act_q.int_v}
                   + {{(RAT_W-OFS_W){offset[OFS_W-1]}}, offset};
        pend_ratio = {1'b0, pend.int_v};
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: IDLE_TO_RUN on a pending legal setting, RUN_HOLD afterwards
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (pend_valid) st_d = ST_RUN;
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs and period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= '0;
            cnt_q     <= '0;
            cur_ratio <= '0;
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= boundary;
            if (apply) begin
                act_q     <= pend;
                cnt_q     <= pend_ratio - RAT_W'(1);
                cur_ratio <= pend_ratio;
            end else if (step) begin
                cnt_q     <= next_ratio - RAT_W'(1);
                cur_ratio <= next_ratio;
            end else if ((st_q == ST_RUN) && in_tick) begin
                cnt_q <= cnt_q - RAT_W'(1);
            end
        end
    end

endmodule

// File: rtl/frac_n_divider_chk.sv
module frac_n_divider_chk
    import frac_div_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_tick,
    input logic                    load,
    input logic [INT_W-1:0]        int_in,
    input logic [MOD_W-1:0]        frac_in,
    input logic [MOD_W-1:0]        mod_in,
    input logic                    div_pulse,
    input logic [RAT_W-1:0]        cur_ratio,
    input logic                    cfg_err,
    input dstate_t                 st_q,
    input logic [RAT_W-1:0]        cnt_q,
    input cfg_t                    act_q,
    input logic signed [OFS_W-1:0] offset
);

    logic in_legal;
    assign in_legal = (int' (int_in) >= INT_MIN) && (int'(mod_in) >= MOD_MIN) &&
                      (int'(frac_in) < int'(mod_in));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> !div_pulse);

    p_illegal_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !in_legal) |=> cfg_err);

    p_legal_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && in_legal) |=> !cfg_err);

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cnt_q < cur_ratio));

    p_ratio_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> ((int'(cur_ratio) >= int'(act_q.int_v) - 3) &&
                       (int'(cur_ratio) <= int'(act_q.int_v) + 4)));

    p_offset_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> ((offset >= -4'sd3) && (offset <= 4'sd4)));

    p_frac_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_RUN) && (act_q.frac_v == '0)) |-> (offset == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_RUN) && !in_tick) |=> $stable(cnt_q));

endmodule

bind frac_n_divider frac_n_divider_chk u_chk (.*);

// File: tb/tb_frac_n_divider.sv
module tb_frac_n_divider;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_tick = 1'b0;
    logic        load = 1'b0;
    logic [8:0]  int_in = '0;
    logic [11:0] frac_in = '0;
    logic [11:0] mod_in = '0;
    logic        div_pulse;
    logic [9:0]  cur_ratio;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit m_run = 0, m_pv = 0;
    int m_rem = 0, m_ai = 0, m_af = 0, m_am = 0, m_pi = 0, m_pf = 0, m_pm = 0;
    int a1 = 0, a2 = 0, a3 = 0, d2 = 0, d3 = 0, d33 = 0;
    bit e_pulse = 0, e_err = 0;
    int e_ratio = 0;
    int per[$];
    int mark = 0;
    int m_cnt = 0;
    bit s_pulse, s_err;
    int s_ratio;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_n_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_tick   (in_tick),
        .load      (load),
        .int_in    (int_in),
        .frac_in   (frac_in),
        .mod_in    (mod_in),
        .div_pulse (div_pulse),
        .cur_ratio (cur_ratio),
        .cfg_err   (cfg_err)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mash_next(output int y);
        int s, c1, c2, c3;
        s = a1 + m_af; c1 = (s >= m_am); if (c1 != 0) s -= m_am; a1 = s;
        s = a2 + a1;   c2 = (s >= m_am); if (c2 != 0) s -= m_am; a2 = s;
        s = a3 + a2;   c3 = (s >= m_am); if (c3 != 0) s -= m_am; a3 = s;
        y = c1 + c2 - d2 + c3 - 2 * d3 + d33;
        d33 = d3; d3 = c3; d2 = c2;
    endtask

    task automatic model_step(bit tk, bit ld, int li, int lf, int lm);
        bit ap = 0;
        bit pl = 0;
        int y;
        if (!m_run) ap = m_pv;
        else if (tk) begin
            if (m_rem == 1) begin
                pl = 1;
                if (m_pv) ap = 1;
                else begin
                    mash_next(y);
                    m_rem = m_ai + y;
                    e_ratio = m_rem;
                end
            end else m_rem--;
        end
        if (ap) begin
            mark = per.size() + (pl ? 1 : 0);
            m_ai = m_pi; m_af = m_pf; m_am = m_pm;
            a1 = m_af; a2 = m_af; a3 = m_af; d2 = 0; d3 = 0; d33 = 0;
            m_rem = m_ai; e_ratio = m_ai; m_run = 1; m_pv = 0;
        end
        e_pulse = pl;
        if (ld) begin
            if (li >= 31 && li <= 511 && lm >= 2 && lm <= 4095 && lf < lm) begin
                m_pi = li; m_pf = lf; m_pm = lm; m_pv = 1; e_err = 0;
            end else e_err = 1;
        end
    endtask

    task automatic cyc(bit tk, bit ld = 0, int li = 0, int lf = 0, int lm = 0);
        @(negedge clk);
        s_pulse = div_pulse; s_ratio = int'(cur_ratio); s_err = cfg_err;
        chk(s_pulse == e_pulse, "R4 pulse timing", s_pulse, e_pulse);
        chk(s_ratio == e_ratio, "R4 current ratio", s_ratio, e_ratio);
        chk(s_err == e_err, "R2 error flag", s_err, e_err);
        if (s_pulse) begin
            per.push_back(m_cnt);
            m_cnt = 0;
        end
        in_tick = tk; load = ld;
        int_in = 9'(li); frac_in = 12'(lf); mod_in = 12'(lm);
        if (m_run && tk) m_cnt++;
        model_step(tk, ld, li, lf, lm);
    endtask

    task automatic run_to_pulse();
        for (int g = 0; g < 3000; g++) begin
            cyc(1);
            if (s_pulse) break;
        end
    endtask

    task automatic analyze(bit want_sum);
        int i = m_ai;
        int f = m_af;
        int m = m_am;
        int sum = 0;
        chk(per.size() > mark, "R7 periods observed", per.size(), mark + 1);
        if (per.size() > mark) chk(per[mark] == i, "R7 first period is INT", per[mark], i);
        for (int k = mark; k < per.size(); k++) begin
            chk(per[k] >= i - 3 && per[k] <= i + 4, "R5 period bounds", per[k], i);
            if (f == 0) chk(per[k] == i, "R6 integer period", per[k], i);
        end
        if (want_sum) begin
            if (per.size() - mark >= m) begin
                for (int k = 0; k < m; k++) sum += per[mark + k];
                chk(sum >= m * i + f - 1 && sum <= m * i + f + 2, "R8 window total",
                    sum, m * i + f);
            end else chk(0, "R8 window length", per.size() - mark, m);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n, old;
        repeat (3) @(negedge clk);
        chk(div_pulse == 0 && cur_ratio == 0 && cfg_err == 0, "R1 reset outputs",
            int'(cur_ratio), 0);
        rst_n = 1'b1;

        // R1: ticks before any setting are ignored
        repeat (6) cyc(1);
        chk(per.size() == 0, "R1 no pulse while idle", per.size(), 0);

        // R2: illegal loads
        cyc(0, 1, 30, 0, 7); cyc(0);
        chk(s_err == 1, "R2 INT below range flagged", s_err, 1);
        cyc(0, 1, 40, 7, 7); cyc(0);
        chk(s_err == 1, "R2 FRAC not below MOD flagged", s_err, 1);
        repeat (4) cyc(1);
        chk(per.size() == 0, "R2 illegal setting not applied", per.size(), 0);

        // R6: integer-only setting
        cyc(0, 1, 40, 0, 7); cyc(0);
        chk(s_err == 0, "R2 legal load clears flag", s_err, 0);
        repeat (450) cyc(1);
        analyze(0);

        // R3: load in mid-period
        while (m_rem < 10) cyc(1);
        old = e_ratio;
        cyc(1, 1, 50, 3, 7);
        cyc(1);
        chk(s_ratio == old, "R3 ratio held until boundary", s_ratio, old);
        run_to_pulse();
        chk(per[$] == old, "R3 running period not truncated", per[$], old);
        chk(s_ratio == 50, "R3 applied at boundary", s_ratio, 50);
        repeat (1300) cyc(1);
        analyze(1);

        // R10: load on the boundary tick while another setting is pending
        while (m_rem < 10) cyc(1);
        cyc(1, 1, 45, 2, 9);
        while (m_rem != 1) cyc(1);
        cyc(1, 1, 60, 1, 5);
        cyc(1);
        chk(s_pulse == 1 && s_ratio == 45, "R10 boundary takes older pending", s_ratio, 45);
        run_to_pulse();
        chk(s_ratio == 60, "R10 colliding load at next boundary", s_ratio, 60);
        repeat (700) cyc(1);
        analyze(1);

        // R11: last load wins
        while (m_rem < 10) cyc(1);
        cyc(1, 1, 70, 4, 13);
        cyc(1);
        cyc(1, 1, 33, 10, 17);
        run_to_pulse();
        chk(s_ratio == 33, "R11 last legal load applied", s_ratio, 33);

        // R2: illegal load while running leaves setting alone
        cyc(1, 1, 33, 20, 17);
        cyc(1);
        chk(s_err == 1, "R2 illegal load in run flagged", s_err, 1);
        repeat (900) cyc(1);
        chk(s_ratio >= 30 && s_ratio <= 37, "R2 illegal load ignored", s_ratio, 33);
        analyze(1);

        // R9: sparse ticks at the smallest INT, then a gap
        cyc(1, 1, 31, 5, 11);
        cyc(1);
        chk(s_err == 0, "R2 flag cleared by legal load", s_err, 0);
        repeat (1500) cyc(1'($urandom_range(0, 1)));
        analyze(1);
        cyc(0);
        n = per.size();
        repeat (60) cyc(0);
        chk(per.size() == n, "R9 no pulse without ticks", per.size(), n);

        // R5: extreme modulus settings
        cyc(1, 1, 511, 4094, 4095);
        repeat (9000) cyc(1);
        analyze(0);
        cyc(1, 1, 31, 4094, 4095);
        repeat (2500) cyc(1);
        analyze(0);

        // R6: integer-only with sparse ticks
        cyc(1, 1, 100, 0, 3);
        repeat (1500) cyc(1'($urandom_range(0, 1)));
        analyze(0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule